// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vector memory operation into a stream of effective addresses, one for each element. A single start pulse captures the operands: a base value, a flag that forces the base term to zero, a signed 16-bit displacement, an access size code, an element count and a shift amount. The block then emits the address for each element index from 0 upward on a valid/ready stream. The element index travels alongside each address.

Three address patterns are available. The first steps the displacement itself per element. The second starts at the displacement and steps by the access size. The third scales the displacement by the access size and multiplies it by a bit-reversed element index, then shifts the product left by a radix-2 span shift. That is the reordering used by one pass of an in-place FFT butterfly. A one-cycle done pulse marks the end of each operation. A downstream load/store unit consumes the stream and does the actual memory accesses.

Top module: `vls_addr_seq`

## Requirements
- R1: With mode code 0 (element stride) and a non-zero displacement, the address for element i is base + sext(disp) * i.
- R2: With mode code 1 (unit stride), the address for element i is base + sext(disp) + size * i. Mode code 3 behaves exactly like mode code 1.
- R3: With mode code 2 (bit-reverse), the address for element i is base + ((sext(disp) * size * rev(i)) << shift). Here rev(i) reverses the low log2(VL) bits of i. For example, with VL = 4 the indices 0,1,2,3 map to 0,2,1,3. VL must be a power of two from 1 to 64.
- R4: When the base-zero flag is high at start, the base term is 0 whatever the base value input carries.
- R5: Mode code 0 with a displacement of zero produces unit-stride addresses (base + size * i).
- R6: Size code 0/1/2/3 selects 1/2/4/8 bytes. All address arithmetic is 64 bits wide and wraps modulo 2^64.
- R7: Elements leave in index order 0 to VL-1. The first index offered is 0, and the index advances only on a cycle where valid and ready are both high.
- R8: While valid is high and ready is low, the address and the index hold their values and valid stays high.
- R9: Done is high for exactly one cycle, on the cycle after the last element is accepted. Valid is low while done is high.
- R10: A start with VL = 0 offers no element and raises done on the cycle after start.
- R11: A start that arrives while a sequence is in progress has no effect on that sequence.
- R12: During and straight after reset, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures the operands and begins a sequence when idle |
| baseVal | input | 64 | Base register value |
| baseIsZero | input | 1 | Forces the base term to zero |
| disp | input | 16 | Signed displacement |
| sizeCode | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| vecLen | input | 7 | Number of elements, 0 to 64 |
| shiftAmt | input | 6 | Left shift applied in bit-reverse mode |
| mode | input | 2 | 0 element stride, 1 unit stride, 2 bit-reverse, 3 unit stride |
| addrReady | input | 1 | Consumer accepts the current address |
| addrValid | output | 1 | An address is offered |
| addrOut | output | 64 | Effective address of the current element |
| elemIdx | output | 6 | Index of the current element |
| done | output | 1 | One-cycle pulse after the last element |

## Verification
The bench builds the block with its default parameters: 64-bit addresses, a 16-bit displacement and a 7-bit element count. These values let VL reach 64, so the full 6-bit bit-reversal can be run end to end, and they let negative displacements and base values near 2^64 show wrap-around. A table of short sequences covers every mode code, size code, the base-zero flag and the zero-displacement fallback. Directed runs then cover a stalled consumer with a start pulse arriving mid-sequence, an empty sequence, and the 8- and 64-element bit-reversed orders.

// File: rtl/vls_addr_seq_pkg.sv
package vls_addr_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ELEM   = 2'd0,
    MODE_UNIT   = 2'd1,
    MODE_BITREV = 2'd2,
    MODE_RSVD   = 2'd3
  } addrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands, clear index
    logic step;   // current element accepted
  } seqStrobe_t;

endpackage

// File: rtl/vls_addr_dp.sv
module vls_addr_dp
  import vls_addr_seq_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 16,
  parameter int VL_W    = 7,
  parameter int SHIFT_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic                baseIsZero,
  input  logic [DISP_W-1:0]   disp,
  input  logic [1:0]          sizeCode,
  input  logic [VL_W-1:0]     vecLen,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  input  logic [1:0]          mode,
  output logic [ADDR_W-1:0]   addrOut,
  output logic [VL_W-2:0]     elemIdx,
  output logic                lastElem
);
  localparam int IDX_W = VL_W - 1;
  localparam int LG_W  = $clog2(VL_W);

  function automatic logic [LG_W-1:0] floorLog2(input logic [VL_W-1:0] v);
    floorLog2 = '0;
    for (int b = 0; b < VL_W; b++) begin
      if (v[b]) floorLog2 = LG_W'(b);
    end
  endfunction

  logic [ADDR_W-1:0]  baseR;
  logic [ADDR_W-1:0]  dispR;
  logic [1:0]         sizeR;
  logic [VL_W-1:0]    vlR;
  logic [SHIFT_W-1:0] shiftR;
  logic [LG_W-1:0]    lgR;
  addrMode_t          modeR;
  logic [IDX_W-1:0]   idxR;

  addrMode_t effMode;
  always_comb begin
    unique case (mode)
      2'd0:    effMode = (disp == '0) ? MODE_UNIT : MODE_ELEM;
      2'd2:    effMode = MODE_BITREV;
      default: effMode = MODE_UNIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR  <= '0;
      dispR  <= '0;
      sizeR  <= '0;
      vlR    <= '0;
      shiftR <= '0;
      lgR    <= '0;
      modeR  <= MODE_UNIT;
      idxR   <= '0;
    end else if (strobe.load) begin
      baseR  <= baseIsZero ? '0 : baseVal;
      dispR  <= ADDR_W'($signed(disp));
      sizeR  <= sizeCode;
      vlR    <= vecLen;
      shiftR <= shiftAmt;
      lgR    <= floorLog2(vecLen);
      modeR  <= effMode;
      idxR   <= '0;
    end else if (strobe.step) begin
      idxR <= idxR + 1'b1;
    end
  end

  // full-width reversal, then drop the unused low bits
  logic [IDX_W-1:0] revFull;
  logic [IDX_W-1:0] revIdx;
  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign revFull[b] = idxR[IDX_W-1-b];
  end
  assign revIdx = revFull >> (IDX_W - int'(lgR));

  logic [ADDR_W-1:0] idxExt;
  logic [ADDR_W-1:0] revExt;
  logic [ADDR_W-1:0] offsetTerm;
  assign idxExt = ADDR_W'(idxR);
  assign revExt = ADDR_W'(revIdx);

  always_comb begin
    unique case (modeR)
      MODE_ELEM:   offsetTerm = dispR * idxExt;
      MODE_BITREV: offsetTerm = ((dispR << sizeR) * revExt) << shiftR;
      default:     offsetTerm = dispR + (idxExt << sizeR);
    endcase
  end

  assign addrOut  = baseR + offsetTerm;
  assign elemIdx  = idxR;
  assign lastElem = (VL_W'(idxR) == (vlR - VL_W'(1)));
endmodule

// File: rtl/vls_seq_ctrl.sv
module vls_seq_ctrl
  import vls_addr_seq_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VL_W-1:0] vecLen,
  input  logic            addrReady,
  input  logic            lastElem,
  output seqStrobe_t      strobe,
  output logic            addrValid,
  output logic            done
);
  logic busy;
  logic accept;

  assign accept      = start && !busy;
  assign strobe.load = accept;
  assign strobe.step = busy && addrReady;
  assign addrValid   = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= (vecLen != '0);
        done <= (vecLen == '0);
      end else if (strobe.step && lastElem) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq
  import vls_addr_seq_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 16,
  parameter int VL_W    = 7,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic               baseIsZero,
  input  logic [DISP_W-1:0]  disp,
  input  logic [1:0]         sizeCode,
  input  logic [VL_W-1:0]    vecLen,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [1:0]         mode,
  input  logic               addrReady,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [VL_W-2:0]    elemIdx,
  output logic               done
);
  seqStrobe_t strobe;
  logic       lastElem;

  vls_seq_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .addrReady(addrReady), .lastElem(lastElem),
    .strobe(strobe), .addrValid(addrValid), .done(done)
  );

  vls_addr_dp #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .VL_W(VL_W), .SHIFT_W(SHIFT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseVal(baseVal),
    .baseIsZero(baseIsZero), .disp(disp), .sizeCode(sizeCode),
    .vecLen(vecLen), .shiftAmt(shiftAmt), .mode(mode),
    .addrOut(addrOut), .elemIdx(elemIdx), .lastElem(lastElem)
  );
endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int VL_W   = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [VL_W-1:0]   vecLen,
  input logic              addrReady,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrOut,
  input logic [VL_W-2:0]   elemIdx,
  input logic              done
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !addrReady |=> addrValid && $stable(addrOut) && $stable(elemIdx)); // R8

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> elemIdx == '0); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && addrReady |=> !addrValid || elemIdx == (VL_W-1)'($past(elemIdx) + 1'b1)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !addrValid); // R9

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    start && !addrValid && vecLen == '0 |=> done && !addrValid); // R10
endmodule

bind vls_addr_seq vls_addr_seq_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
  .addrReady(addrReady), .addrValid(addrValid), .addrOut(addrOut),
  .elemIdx(elemIdx), .done(done)
);

// File: tb/vls_addr_seq_bench.sv
`timescale 1ns/1ps
module vls_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] baseVal = '0;
  logic        baseIsZero = 1'b0;
  logic [15:0] disp = '0;
  logic [1:0]  sizeCode = '0;
  logic [6:0]  vecLen = '0;
  logic [5:0]  shiftAmt = '0;
  logic [1:0]  mode = '0;
  logic        addrReady = 1'b1;
  logic        addrValid;
  logic [63:0] addrOut;
  logic [5:0]  elemIdx;
  logic        done;

  always #2.5 clk = ~clk;

  vls_addr_seq u_vls_addr_seq (
    .clk(clk), .rstN(rstN), .start(start), .baseVal(baseVal),
    .baseIsZero(baseIsZero), .disp(disp), .sizeCode(sizeCode),
    .vecLen(vecLen), .shiftAmt(shiftAmt), .mode(mode),
    .addrReady(addrReady), .addrValid(addrValid), .addrOut(addrOut),
    .elemIdx(elemIdx), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // mode, base, baseIsZero, disp, sizeCode, vecLen, shift, expected addresses
  localparam int NV = 9;
  localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [63:0] V_BASE [NV] = '{64'h10, 64'h10, 64'h10, 64'h100, 64'hDEAD,
                                          64'h1000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h20};
  localparam logic        V_BZ   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [15:0] V_DISP [NV] = '{16'd24, 16'd8, 16'd4, 16'd1, 16'hFFF8,
                                          16'd0, 16'd2, 16'd16, 16'd4};
  localparam logic [1:0]  V_SZ   [NV] = '{2'd2, 2'd2, 2'd0, 2'd3, 2'd1, 2'd2, 2'd1, 2'd0, 2'd2};
  localparam logic [6:0]  V_VL   [NV] = '{7'd2, 7'd2, 7'd4, 7'd4, 7'd3, 7'd3, 7'd2, 7'd2, 7'd2};
  localparam logic [5:0]  V_SH   [NV] = '{6'd0, 6'd0, 6'd0, 6'd2, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0};
  localparam logic [63:0] V_EXP  [NV][4] = '{
    '{64'h10,  64'h28,  64'h0,   64'h0},                        // R1
    '{64'h18,  64'h1C,  64'h0,   64'h0},                        // R2
    '{64'h10,  64'h18,  64'h14,  64'h1C},                       // R3
    '{64'h100, 64'h140, 64'h120, 64'h160},                      // R3 R6 size 8, shift 2
    '{64'h0, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0}, // R4 R1
    '{64'h1000, 64'h1004, 64'h1008, 64'h0},                     // R5
    '{64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'h0, 64'h0},            // R6 wrap
    '{64'h0,   64'h10,  64'h0,   64'h0},                        // R3 VL=2
    '{64'h24,  64'h28,  64'h0,   64'h0}                         // R2 code 3
  };

  function automatic string tagOf(input int v);
    case (v)
      0: tagOf = "R1";
      1: tagOf = "R2";
      2: tagOf = "R3";
      3: tagOf = "R6";
      4: tagOf = "R4";
      5: tagOf = "R5";
      6: tagOf = "R6";
      7: tagOf = "R3";
      default: tagOf = "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] m, input logic [63:0] b, input logic bz,
                        input logic [15:0] d, input logic [1:0] sc, input logic [6:0] vl,
                        input logic [5:0] sh);
    @(negedge clk);
    mode = m; baseVal = b; baseIsZero = bz; disp = d;
    sizeCode = sc; vecLen = vl; shiftAmt = sh; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // after the last accepted element: done for one cycle, valid low
  task automatic checkEnd(input string req);
    check(done == 1'b1 && addrValid == 1'b0, req, {62'd0, done, addrValid}, 64'h2);
    @(negedge clk);
    check(done == 1'b0, req, {63'd0, done}, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check(addrValid == 1'b0 && done == 1'b0, "R12", {62'd0, addrValid, done}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(addrValid == 1'b0 && done == 1'b0, "R12", {62'd0, addrValid, done}, 64'h0);

    // table walk with ready held high
    for (int v = 0; v < NV; v++) begin
      launch(V_MODE[v], V_BASE[v], V_BZ[v], V_DISP[v], V_SZ[v], V_VL[v], V_SH[v]);
      for (int k = 0; k < int'(V_VL[v]); k++) begin
        check(addrValid && elemIdx == 6'(k), "R7", {58'd0, elemIdx}, 64'(k));
        check(addrOut == V_EXP[v][k], tagOf(v), addrOut, V_EXP[v][k]);
        @(negedge clk);
      end
      checkEnd("R9");
    end

    // R10: empty sequence
    launch(2'd1, 64'h40, 1'b0, 16'd4, 2'd2, 7'd0, 6'd0);
    checkEnd("R10");

    // R8 and R11: stall, then a start pulse during the sequence
    addrReady = 1'b0;
    launch(2'd0, 64'h10, 1'b0, 16'd24, 2'd2, 7'd2, 6'd0);
    for (int k = 0; k < 3; k++) begin
      check(addrValid && addrOut == 64'h10 && elemIdx == 6'd0, "R8", addrOut, 64'h10);
      if (k == 1) begin
        mode = 2'd1; baseVal = 64'h5000; vecLen = 7'd3; disp = 16'd0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(addrValid && addrOut == 64'h10, "R11", addrOut, 64'h10);
    addrReady = 1'b1;
    @(negedge clk);
    check(addrValid && addrOut == 64'h28 && elemIdx == 6'd1, "R11", addrOut, 64'h28);
    @(negedge clk);
    checkEnd("R11");

    // R3: 8-element bit-reversed order
    launch(2'd2, 64'h0, 1'b0, 16'd1, 2'd0, 7'd8, 6'd0);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] e;
      e = {61'd0, 3'(k) & 3'b001, 2'b00} | {62'd0, 3'(k) & 3'b010, 1'b0} >> 1 | 64'(k >> 2);
      e = 64'({k[0], k[1], k[2]});
      check(addrOut == e, "R3", addrOut, e);
      @(negedge clk);
    end
    checkEnd("R9");

    // R3: 64-element bit-reversed order, the largest VL
    launch(2'd2, 64'h8000, 1'b0, 16'd1, 2'd0, 7'd64, 6'd0);
    for (int k = 0; k < 64; k++) begin
      logic [5:0] r;
      for (int b = 0; b < 6; b++) r[b] = k[5-b];
      check(addrOut == 64'h8000 + 64'(r), "R3", addrOut, 64'h8000 + 64'(r));
      @(negedge clk);
    end
    checkEnd("R9");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule